// File: doc/BRIEF.md
# External DMA Request Detector

This block watches an external DMA request line for one channel and turns what it sees into transfer starts. Each start is a one-cycle pulse, and an acknowledge pulse appears in the same cycle. The request line can be sensed in four ways: on a rising edge, on a falling edge, while it is high, or while it is low. The request logic does not care which way data moves. The request source may be a device that is neither the source nor the destination of the data.

A down-counter holds the number of transfers the channel will perform. It is loaded while the channel is disabled and steps down once for each transfer-done strobe from the bus engine. When the counter reaches zero the channel stops and raises a sticky complete flag. In edge sensing, burst mode turns a single edge into back-to-back transfers until the count runs out. Cycle-steal mode gives one transfer per accepted request. In level sensing, an overrun option samples the line once more just after the acknowledge. A device that drops its request on seeing the acknowledge then receives one extra transfer.

Top module: `ext_req_detect`

## Requirements
- R1: With the mode bits edgeSel=1, senseSel=1 (rising) or edgeSel=1, senseSel=0 (falling), one active transition of the synchronised request line starts exactly one transfer in cycle-steal mode, and the return transition starts none.
- R2: With edgeSel=0 and overrunSel=0, the line is sensed at senseSel (1 = high, 0 = low). If a device holds the line active and releases it on its Nth acknowledge, exactly N transfers are started.
- R3: With edgeSel=0 and overrunSel=1, the same device receives N+1 transfers, always bounded by the remaining transfer count.
- R4: With edge sensing and burstMode=1, a single edge starts transfers back to back until the count reaches zero, and then the complete flag rises.
- R5: With edge sensing and burstMode=0, each accepted edge gives exactly one transfer. The total is the smaller of the edge count and the loaded count.
- R6: ack is high exactly in the cycles in which xferStart is high, and each start pulse lasts one cycle.
- R7: Edges that arrive between acceptance and acknowledge are ignored. Once acknowledge has been given, at most one further request is remembered while a transfer is in flight, however many edges arrive.
- R8: The count never rises while the channel is enabled. Once it reaches zero, chanDone stays high and no start is issued until the channel is disabled.
- R9: chanEn=0 discards any remembered request, reloads the count from countLoad and clears chanDone. Re-enabling with the line already at the active level of an edge mode starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqPin | input | 1 | Raw external request line |
| edgeSel | input | 1 | 1 = edge sensing, 0 = level sensing |
| senseSel | input | 1 | 1 = rising/high, 0 = falling/low |
| burstMode | input | 1 | 1 = burst, 0 = cycle steal |
| overrunSel | input | 1 | Level mode: 1 = one extra transfer |
| chanEn | input | 1 | Channel enable; low reloads and clears |
| countLoad | input | CNT_W | Transfer count loaded while disabled |
| xferDone | input | 1 | One-cycle strobe from the bus engine when a transfer ends |
| xferStart | output | 1 | One-cycle transfer start pulse |
| ack | output | 1 | Acknowledge to the requesting device |
| chanDone | output | 1 | Sticky channel-complete flag |

## Verification
The bench drives a device that holds a level request and drops it on the acknowledge. If the overrun sampling were off by one cycle, that device would get the wrong number of transfers: an extra one with overrun off, or none with overrun on. A slow bus engine is paired with a burst of edges during one transfer. A design that queued every edge, or forgot the remembered one, would start too many or too few transfers. Disabling mid-transfer and then re-enabling with the line parked high catches a stale remembered request, a count that is not reloaded, and a false edge from stale history. Random edge trains with random counts and engine delays cover the cases where the count runs out before the edges do, and the reverse.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT
  } chanState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } dpStrobe_t;
endpackage

// File: rtl/dreq_datapath.sv
module dreq_datapath
  import dreq_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPin,
  input  logic             edgeSel,
  input  logic             senseSel,
  input  logic [CNT_W-1:0] countLoad,
  input  dpStrobe_t        strb,
  output logic             reqHit,
  output logic             cntZero,
  output logic             cntLast,
  output logic             doneFlag,
  output logic [CNT_W-1:0] countQ
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sampled;
  logic                   prevQ;

  // Synchroniser chain for the asynchronous request line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], reqPin};
  end
  assign sampled = syncQ[SYNC_STAGES-1];

  // History follows the sampled line at all times, also while disabled,
  // so enabling never sees a stale transition.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= sampled;
  end

  always_comb begin
    if (edgeSel) reqHit = senseSel ? (sampled & ~prevQ) : (~sampled & prevQ);
    else         reqHit = (sampled == senseSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      doneFlag <= 1'b0;
    end else if (strb.loadCnt) begin
      countQ   <= countLoad;
      doneFlag <= 1'b0;
    end else if (strb.decCnt && !cntZero) begin
      countQ <= countQ - CNT_ONE;
      if (cntLast) doneFlag <= 1'b1;
    end
  end

  assign cntZero = (countQ == '0);
  assign cntLast = (countQ == CNT_ONE);
endmodule

// File: rtl/dreq_control.sv
module dreq_control
  import dreq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chanEn,
  input  logic      edgeSel,
  input  logic      burstMode,
  input  logic      overrunSel,
  input  logic      xferDone,
  input  logic      reqHit,
  input  logic      cntZero,
  input  logic      cntLast,
  input  logic      doneFlag,
  output logic      xferStart,
  output logic      ack,
  output dpStrobe_t strb
);
  chanState_t stateQ;
  logic       pendQ;      // one remembered request while busy
  logic       firstWaitQ; // first cycle after the acknowledge
  logic       canRun;
  logic       capture;

  assign canRun  = !cntZero && !doneFlag;
  // Edge mode listens for the whole busy time after the acknowledge;
  // level mode with overrun samples only the cycle right after it.
  assign capture = edgeSel ? reqHit : (overrunSel && firstWaitQ && reqHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      pendQ      <= 1'b0;
      firstWaitQ <= 1'b0;
    end else if (!chanEn) begin
      stateQ     <= ST_IDLE;
      pendQ      <= 1'b0;
      firstWaitQ <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if ((reqHit || pendQ) && canRun) begin
            stateQ <= ST_START;
            pendQ  <= 1'b0;
          end
        end
        ST_START: begin
          stateQ     <= ST_WAIT;
          firstWaitQ <= 1'b1;
        end
        ST_WAIT: begin
          firstWaitQ <= 1'b0;
          if (capture) pendQ <= 1'b1;
          if (xferDone) begin
            if (cntLast)                    stateQ <= ST_IDLE;
            else if (edgeSel && burstMode)  stateQ <= ST_START;
            else                            stateQ <= ST_IDLE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign xferStart    = (stateQ == ST_START);
  assign ack          = (stateQ == ST_START);
  assign strb.loadCnt = !chanEn;
  assign strb.decCnt  = chanEn && (stateQ == ST_WAIT) && xferDone;
endmodule

// File: rtl/ext_req_detect.sv
module ext_req_detect
  import dreq_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPin,
  input  logic             edgeSel,
  input  logic             senseSel,
  input  logic             burstMode,
  input  logic             overrunSel,
  input  logic             chanEn,
  input  logic [CNT_W-1:0] countLoad,
  input  logic             xferDone,
  output logic             xferStart,
  output logic             ack,
  output logic             chanDone
);
  dpStrobe_t        strb;
  logic             reqHit;
  logic             cntZero;
  logic             cntLast;
  logic [CNT_W-1:0] countQ;

  dreq_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .reqPin(reqPin), .edgeSel(edgeSel),
    .senseSel(senseSel), .countLoad(countLoad), .strb(strb),
    .reqHit(reqHit), .cntZero(cntZero), .cntLast(cntLast),
    .doneFlag(chanDone), .countQ(countQ)
  );

  dreq_control ctl_i (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .edgeSel(edgeSel),
    .burstMode(burstMode), .overrunSel(overrunSel), .xferDone(xferDone),
    .reqHit(reqHit), .cntZero(cntZero), .cntLast(cntLast),
    .doneFlag(chanDone), .xferStart(xferStart), .ack(ack), .strb(strb)
  );
endmodule

// File: rtl/dreq_checker.sv
module dreq_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic             xferStart,
  input logic             doneFlag,
  input logic [CNT_W-1:0] countQ
);
  p_start_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

  p_no_start_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !xferStart);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && $past(chanEn) && $past(doneFlag)) |-> doneFlag);

  p_count_monotone_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && $past(chanEn)) |-> (countQ <= $past(countQ)));

  p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !xferStart);
endmodule

bind ext_req_detect dreq_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferStart(xferStart),
  .doneFlag(chanDone), .countQ(countQ)
);

// File: tb/ext_req_detect_tb.sv
module ext_req_detect_tb_top;
  localparam int CNT_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPin = 1'b0;
  logic edgeSel = 1'b1, senseSel = 1'b1, burstMode = 1'b0, overrunSel = 1'b0;
  logic chanEn = 1'b0;
  logic [CNT_W-1:0] countLoad = '0;
  logic xferDone = 1'b0;
  logic xferStart, ack, chanDone;

  int checks = 0, fails = 0;
  int starts = 0;
  int dly = 0;
  int slowDly = 0;
  int levelDrop = 0;
  logic levelActive = 1'b1;
  logic prevStart = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_req_detect #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqPin(reqPin), .edgeSel(edgeSel),
    .senseSel(senseSel), .burstMode(burstMode), .overrunSel(overrunSel),
    .chanEn(chanEn), .countLoad(countLoad), .xferDone(xferDone),
    .xferStart(xferStart), .ack(ack), .chanDone(chanDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor, bus-engine responder and level device, all away from the clock edge
  always @(negedge clk) begin
    xferDone = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) xferDone = 1'b1;
    end
    if (ack || xferStart) chk(ack == xferStart, "R6 ack/start", ack, xferStart);
    if (xferStart) chk(!prevStart, "R6 single pulse", 1, 0);
    prevStart = xferStart;
    if (xferStart) begin
      starts++;
      dly = (slowDly > 0) ? slowDly : 1 + int'($urandom % 3);
      if (levelDrop != 0 && starts == levelDrop) reqPin = ~levelActive;
    end
  end

  task automatic setup(input logic e, input logic s, input logic b, input logic o,
                       input int cnt, input logic idleLvl);
    @(negedge clk);
    chanEn = 1'b0;
    edgeSel = e; senseSel = s; burstMode = b; overrunSel = o;
    countLoad = CNT_W'(cnt);
    reqPin = idleLvl;
    levelDrop = 0;
    repeat (6) @(negedge clk);
    starts = 0;
    chanEn = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic act, input int hi, input int gap);
    reqPin = act;
    repeat (hi) @(negedge clk);
    reqPin = ~act;
    repeat (gap) @(negedge clk);
  endtask

  task automatic level_run(input logic act, input logic ov, input int cnt, input int n,
                           input int expStarts, input bit expDone, input string tag);
    setup(1'b0, act, 1'b0, ov, cnt, ~act);
    levelActive = act;
    levelDrop = n;
    reqPin = act;
    repeat (60) @(negedge clk);
    chk(starts == expStarts, tag, starts, expStarts);
    chk(chanDone == expDone, tag, int'(chanDone), int'(expDone));
    levelDrop = 0;
  endtask

  function automatic int min_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    process::self().srandom(32'h5eed_0042);
    repeat (4) @(negedge clk);
    chk(xferStart == 1'b0 && ack == 1'b0, "R6 reset outputs", int'(xferStart), 0);
    chk(chanDone == 1'b0, "R8 reset done", int'(chanDone), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: rising and falling edge sensing, one pulse -> one transfer
    setup(1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b0);
    pulse(1'b1, 6, 20);
    chk(starts == 1, "R1 rising", starts, 1);
    setup(1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b1);
    pulse(1'b0, 6, 20);
    chk(starts == 1, "R1 falling", starts, 1);

    // R2 / R3: level sensing with and without overrun
    level_run(1'b1, 1'b0, 20, 3, 3, 1'b0, "R2 high ov0");
    level_run(1'b0, 1'b0, 20, 4, 4, 1'b0, "R2 low ov0");
    level_run(1'b1, 1'b1, 20, 3, 4, 1'b0, "R3 high ov1");
    level_run(1'b0, 1'b1, 20, 2, 3, 1'b0, "R3 low ov1");
    level_run(1'b1, 1'b1, 3, 3, 3, 1'b1, "R3 count bound");

    // R4: burst from one edge, then R8 sticky done
    setup(1'b1, 1'b1, 1'b1, 1'b0, 5, 1'b0);
    pulse(1'b1, 3, 40);
    chk(starts == 5, "R4 burst count", starts, 5);
    chk(chanDone == 1'b1, "R4 burst done", int'(chanDone), 1);
    pulse(1'b1, 3, 20);
    chk(starts == 5, "R8 no start after done", starts, 5);
    chk(chanDone == 1'b1, "R8 done sticky", int'(chanDone), 1);

    // R7: many edges while one transfer is in flight -> one remembered
    setup(1'b1, 1'b1, 1'b0, 1'b0, 10, 1'b0);
    slowDly = 40;
    pulse(1'b1, 3, 6);
    for (int i = 0; i < 3; i++) pulse(1'b1, 3, 6);
    slowDly = 0;
    repeat (60) @(negedge clk);
    chk(starts == 2, "R7 one remembered", starts, 2);

    // R9: disable mid-transfer with a remembered edge, reload, no false edge
    setup(1'b1, 1'b1, 1'b0, 1'b0, 10, 1'b0);
    slowDly = 40;
    pulse(1'b1, 3, 6);
    pulse(1'b1, 3, 4);
    chanEn = 1'b0;
    countLoad = CNT_W'(2);
    reqPin = 1'b1;
    repeat (45) @(negedge clk);
    slowDly = 0;
    chk(chanDone == 1'b0, "R9 done cleared", int'(chanDone), 0);
    chanEn = 1'b1;
    repeat (30) @(negedge clk);
    chk(starts == 1, "R9 pending dropped, no false edge", starts, 1);
    reqPin = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b1, 3, 15);
    pulse(1'b1, 3, 15);
    pulse(1'b1, 3, 15);
    chk(starts == 3, "R9 count reloaded", starts, 3);
    chk(chanDone == 1'b1, "R9 reload reaches done", int'(chanDone), 1);

    // R5: random cycle-steal edge trains
    for (int t = 0; t < 10; t++) begin
      automatic logic rise = logic'($urandom % 2);
      automatic int cnt = 3 + int'($urandom % 6);
      automatic int edges = 2 + int'($urandom % 9);
      automatic int exp = min_of(edges, cnt);
      setup(1'b1, rise, 1'b0, 1'b0, cnt, ~rise);
      for (int k = 0; k < edges; k++) pulse(rise, 3, 8 + int'($urandom % 7));
      repeat (30) @(negedge clk);
      chk(starts == exp, "R5 random steal", starts, exp);
      chk(chanDone == (edges >= cnt), "R5 random done", int'(chanDone), int'(edges >= cnt));
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule